// File: doc/BRIEF.md
# Collatz Odd-Step Iteration Engine

This block runs the compressed Collatz map on one start value. It works only on odd values. One step takes an odd value n to (3n+1) with its trailing zeros removed. A single-cycle datapath forms (3n+1)/2 and then shifts right by up to three more bits. The shift amount is decoded from the low bits of n while the add is running. If the value is still even after that shortcut, the following cycles halve it one bit at a time until it is odd again. Those halving cycles do not add to the step count.

A run is started through a valid/ready handshake that carries three things: the start value, a record step count and a preset maximum. The engine then iterates on its own until a stop condition holds. It can stop because the value fell below the start, because the step count went past the record, because the value went past the preset maximum, or because the arithmetic would leave the datapath width. The results are then held on the output side until they are acknowledged: the final value, the step count, the peak value and the stop flags. Several such engines can run side by side, each checking its own start values.

Top module: `collatz_engine`

## Requirements
- R1: `in_ready` is high only while the engine is idle. A run is accepted on a clock edge where `in_valid` and `in_ready` are both high. While a run is in progress, `in_valid` and the input fields have no effect on the result, and `in_ready` stays low.
- R2: Bit 0 of `in_start` is ignored and taken as 1. An even start value 2k gives exactly the results of the start value 2k+1.
- R3: Each clock cycle that begins with an odd value performs one step and adds 1 to the step count. The step replaces the value with (3n+1)/2 and then shifts it right while it is even, by at most 3 further bits. The result appears after the same clock edge. A run from 3 gives value 1, count 2, peak 5 after 2 iteration cycles.
- R4: A cycle that begins with an even value halves it and leaves the count unchanged. A run from 255 gives value 205, count 8, peak 4373 after 10 iteration cycles, the last two of them halving.
- R5: The run stops when a newly computed value is smaller than the start value, and the drop flag is raised.
- R6: The run stops when a step makes the count greater than the loaded record, and the record flag is raised. Start 27 with record 2 ends at value 47 with count 3.
- R7: The run stops when a newly computed value is greater than the preset maximum, and the new-maximum flag is raised. `out_peak` is the largest value held during the run, the start included. Start 27 with maximum 100 ends at value 107 with peak 107 and count 5.
- R8: If 3n+1 is at least 2^W, the run stops with only the overflow flag raised. Value, count and peak keep their previous contents. A start of (2^W-1)/3 overflows on its first cycle. A start 2 below that takes one step to 2^(W-1)-3 and then overflows.
- R9: `out_valid` rises when the run stops. All result outputs hold steady until a cycle where `out_ready` is high. On that cycle the engine returns to idle, so `out_valid` falls and `in_ready` rises after that edge.
- R10: After reset, `in_ready` is 1 and `out_valid` is 0.
- R11: Every non-overflow stop condition that holds in the final cycle is flagged together. Start 255 with record 2 and maximum 800 ends at value 863 with count 3 and both the record and new-maximum flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Run request valid |
| in_ready | output | 1 | Engine idle, request can be taken |
| in_start | input | W (128) | Start value, bit 0 taken as 1 |
| in_record | input | CW (32) | Record step count to beat |
| in_max | input | W (128) | Preset maximum value |
| out_valid | output | 1 | Results valid |
| out_ready | input | 1 | Results acknowledged |
| out_value | output | W (128) | Final value of the run |
| out_count | output | CW (32) | Odd steps taken |
| out_peak | output | W (128) | Largest value held during the run |
| out_drop | output | 1 | Stopped: value fell below start |
| out_record | output | 1 | Stopped: count passed record |
| out_newmax | output | 1 | Stopped: value passed preset maximum |
| out_ovf | output | 1 | Stopped: step would overflow W bits |

## Verification
An error in the value register or in the shift decode changes the trajectory at once. It then shows up at the ports as a wrong final value, a wrong count or a wrong number of cycles before `out_valid` rises. A count that also advances on halving cycles appears in the 255 run as count 10 instead of 8. A wrong overflow bound either stops the 0x55…53 run one step early or lets a corrupted value through. A stop decision that gives one flag priority over another would drop a flag in the record-plus-maximum case. Results that are not held would change across the cycles in which the bench keeps `out_ready` low.

// File: rtl/collatz_pkg.sv
package collatz_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } run_st_e;

  typedef struct packed {
    logic ovf;
    logic newmax;
    logic record;
    logic drop;
  } stop_t;

endpackage

// File: rtl/collatz_shdec.sv
// Decodes the extra right shift after (3n+1)/2 from the low bits of odd n.
module collatz_shdec #(
  parameter int SHL = 2
) (
  input  logic [(1<<SHL)-1:1] nbits,
  output logic [SHL-1:0]      sh
);
  localparam int TW  = 1 << SHL;
  localparam int CAP = TW - 1;

  logic [TW-1:0] nl;
  logic [TW-1:0] t;

  always_comb begin
    nl = {nbits, 1'b1};
    t  = nl + {nl[TW-2:0], 1'b0} + TW'(1);   // low bits of 3n+1
  end

  // index of the lowest set bit above bit 0, less one, capped
  always_comb begin
    sh = SHL'(CAP);
    for (int i = CAP; i >= 1; i--) begin
      if (t[i]) sh = SHL'(i - 1);
    end
  end
endmodule

// File: rtl/collatz_step.sv
// One iteration: odd value -> add stage plus short shift; even value -> halve.
module collatz_step #(
  parameter int W   = 128,
  parameter int SHL = 2
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] nxt,
  output logic         odd,
  output logic         ovf
);
  localparam int TW = 1 << SHL;

  logic [SHL-1:0] sh;
  logic [W:0]     h;
  logic [W-1:0]   stg [SHL+1];

  collatz_shdec #(.SHL(SHL)) u_dec (
    .nbits (val[TW-1:1]),
    .sh    (sh)
  );

  assign odd = val[0];
  // (3n+1)/2 = n + floor(n/2) + 1 for odd n
  assign h   = {1'b0, val} + {2'b00, val[W-1:1]} + (W+1)'(1);
  // 3n+1 >= 2^W exactly when (3n+1)/2 >= 2^(W-1)
  assign ovf = odd & (h[W] | h[W-1]);

  assign stg[0] = h[W-1:0];
  for (genvar g = 0; g < SHL; g++) begin : g_shift
    assign stg[g+1] = sh[g] ? (stg[g] >> (1 << g)) : stg[g];
  end

  assign nxt = odd ? stg[SHL] : {1'b0, val[W-1:1]};
endmodule

// File: rtl/collatz_engine.sv
module collatz_engine
  import collatz_pkg::*;
#(
  parameter int W   = 128,
  parameter int CW  = 32,
  parameter int SHL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_start,
  input  logic [CW-1:0] in_record,
  input  logic [W-1:0]  in_max,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_value,
  output logic [CW-1:0] out_count,
  output logic [W-1:0]  out_peak,
  output logic          out_drop,
  output logic          out_record,
  output logic          out_newmax,
  output logic          out_ovf
);
  run_st_e       st_q, st_d;
  logic [W-1:0]  start_q, max_q, val_q, peak_q;
  logic [CW-1:0] rec_q, cnt_q;
  stop_t         fl_q, fl_d;

  logic [W-1:0]  val_d, peak_d, s_in, nxt;
  logic [CW-1:0] cnt_d;
  logic [CW:0]   cnt_x;
  logic          odd, ovf;
  logic          ld_en, run_en, upd;
  logic          cfg_en, val_en, cnt_en, peak_en, fl_en;
  logic          hit_drop, hit_rec, hit_max;

  collatz_step #(.W(W), .SHL(SHL)) u_step (
    .val (val_q),
    .nxt (nxt),
    .odd (odd),
    .ovf (ovf)
  );

  assign s_in = in_start | W'(1);

  // ---------------- control ----------------
  always_comb begin
    st_d   = st_q;
    ld_en  = 1'b0;
    run_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (in_valid) begin
        st_d  = ST_RUN;
        ld_en = 1'b1;
      end
      ST_RUN: begin
        run_en = 1'b1;
        if (ovf || hit_drop || hit_rec || hit_max) st_d = ST_DONE;
      end
      ST_DONE: if (out_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // ---------------- datapath next values ----------------
  always_comb begin
    upd      = run_en & ~ovf;
    cnt_x    = {1'b0, cnt_q} + (CW+1)'(odd);
    hit_drop = nxt < start_q;
    hit_rec  = odd & (cnt_x > {1'b0, rec_q});
    hit_max  = nxt > max_q;

    cfg_en  = ld_en;
    val_en  = ld_en | upd;
    cnt_en  = ld_en | (upd & odd);
    peak_en = ld_en | (upd & (nxt > peak_q));
    fl_en   = ld_en | run_en;

    val_d  = ld_en ? s_in : nxt;
    peak_d = ld_en ? s_in : nxt;
    cnt_d  = ld_en ? '0 : (cnt_x[CW] ? '1 : cnt_x[CW-1:0]);

    fl_d = '0;
    if (run_en) begin
      if (ovf) begin
        fl_d.ovf = 1'b1;
      end else begin
        fl_d.drop   = hit_drop;
        fl_d.record = hit_rec;
        fl_d.newmax = hit_max;
      end
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      max_q   <= '0;
      rec_q   <= '0;
    end else if (cfg_en) begin
      start_q <= s_in;
      max_q   <= in_max;
      rec_q   <= in_record;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       peak_q <= '0;
    else if (peak_en) peak_q <= peak_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fl_q <= '0;
    else if (fl_en) fl_q <= fl_d;
  end

  // ---------------- outputs ----------------
  assign in_ready   = (st_q == ST_IDLE);
  assign out_valid  = (st_q == ST_DONE);
  assign out_value  = val_q;
  assign out_count  = cnt_q;
  assign out_peak   = peak_q;
  assign out_drop   = fl_q.drop;
  assign out_record = fl_q.record;
  assign out_newmax = fl_q.newmax;
  assign out_ovf    = fl_q.ovf;

  // ---------------- assertions ----------------
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_value) &&
      $stable(out_count) && $stable(out_peak) && $stable(fl_q))); // R9

  AST_EVEN_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !val_q[0]) |=> (cnt_q == $past(cnt_q))); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && ovf) |=> (val_q == $past(val_q) && cnt_q == $past(cnt_q))); // R8

  AST_OVF_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> !(out_drop || out_record || out_newmax)); // R8

  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_drop || out_record || out_newmax || out_ovf)); // R11

  AST_PEAK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_peak >= out_value)); // R7

  AST_ODD_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && val_q[0] && !ovf && st_d == ST_RUN)
      |=> (cnt_q == $past(cnt_q) + CW'(1))); // R3
endmodule

// File: tb/collatz_engine_test.sv
module collatz_engine_test;
  localparam int CLK_NS = 10;
  localparam int W  = 128;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_ready, out_valid, out_ready;
  logic [W-1:0]  in_start, in_max, out_value, out_peak;
  logic [CW-1:0] in_record, out_count;
  logic          out_drop, out_record, out_newmax, out_ovf;

  collatz_engine #(.W(W), .CW(CW), .SHL(2)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_record(in_record), .in_max(in_max),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_value(out_value), .out_count(out_count), .out_peak(out_peak),
    .out_drop(out_drop), .out_record(out_record),
    .out_newmax(out_newmax), .out_ovf(out_ovf)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic [W-1:0]  r_val, r_peak;
  logic [CW-1:0] r_cnt;
  logic [3:0]    r_fl;   // [0] drop [1] record [2] newmax [3] overflow
  int            r_cyc;

  localparam logic [W-1:0]  ALL1W  = '1;
  localparam logic [CW-1:0] ALL1C  = '1;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Independent reference: cycle-by-cycle walk of the requirements.
  function automatic void model(input logic [W-1:0] s0, input logic [CW-1:0] rec,
                                input logic [W-1:0] mx, output logic [W-1:0] v,
                                output logic [CW-1:0] c, output logic [W-1:0] pk,
                                output logic [3:0] fl, output int cyc);
    logic [W+1:0] x;
    logic [W-1:0] s;
    logic [CW:0]  cc;
    s = s0 | W'(1); v = s; cc = '0; pk = s; fl = '0; cyc = 0;
    for (int k = 0; k < 100000; k++) begin
      cyc++;
      if (v[0]) begin
        x = 3 * {2'b00, v} + 1;
        if (x[W+1:W] != 2'b00) begin
          fl[3] = 1'b1;
          break;
        end
        x = x >> 1;
        for (int j = 0; j < 3; j++) if (!x[0]) x = x >> 1;
        v  = x[W-1:0];
        cc = cc + 1;
        if (cc > {1'b0, rec}) fl[1] = 1'b1;
      end else begin
        v = v >> 1;
      end
      if (v > pk) pk = v;
      if (v < s)  fl[0] = 1'b1;
      if (v > mx) fl[2] = 1'b1;
      if (fl != 4'b0) break;
    end
    c = cc[CW-1:0];
  endfunction

  // Launch one run, wait for results, hold them ack_wait cycles, then acknowledge.
  task automatic run(input logic [W-1:0] s, input logic [CW-1:0] rec,
                     input logic [W-1:0] mx, input bit poke, input int ack_wait);
    @(negedge clk);
    chk("R1 ready before launch", W'(in_ready), W'(1));
    in_start = s; in_record = rec; in_max = mx; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (poke) begin
      in_valid = 1'b1; in_start = 3; in_record = '0; in_max = '0;
    end
    r_cyc = 0;
    while (!out_valid && r_cyc < 100000) begin
      @(negedge clk);
      r_cyc++;
      if (poke && r_cyc <= 3) chk("R1 ready low while busy", W'(in_ready), W'(0));
      if (r_cyc == 3) in_valid = 1'b0;
    end
    if (!out_valid) begin
      n_chk++; n_bad++;
      $display("FAIL R3 run did not finish actual=0 expected=1");
    end
    r_val = out_value; r_cnt = out_count; r_peak = out_peak;
    r_fl  = {out_ovf, out_newmax, out_record, out_drop};
    for (int k = 0; k < ack_wait; k++) begin
      @(negedge clk);
      chk("R9 valid held", W'(out_valid), W'(1));
      chk("R9 value held", out_value, r_val);
      chk("R9 count held", W'(out_count), W'(r_cnt));
      chk("R9 peak held",  out_peak, r_peak);
      chk("R9 flags held", W'({out_ovf, out_newmax, out_record, out_drop}), W'(r_fl));
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R9 valid falls after ack", W'(out_valid), W'(0));
    chk("R9 ready returns after ack", W'(in_ready), W'(1));
  endtask

  task automatic vs_model(input string tag, input logic [W-1:0] s,
                          input logic [CW-1:0] rec, input logic [W-1:0] mx, input bit poke);
    logic [W-1:0] ev, ep; logic [CW-1:0] ec; logic [3:0] ef; int ecyc;
    model(s, rec, mx, ev, ec, ep, ef, ecyc);
    run(s, rec, mx, poke, 0);
    chk({tag, " value"},  r_val, ev);
    chk({tag, " count"},  W'(r_cnt), W'(ec));
    chk({tag, " peak"},   r_peak, ep);
    chk({tag, " flags"},  W'(r_fl), W'(ef));
    chk({tag, " cycles"}, W'(r_cyc), W'(ecyc));
  endtask

  task automatic t_reset;
    chk("R10 ready after reset", W'(in_ready), W'(1));
    chk("R10 valid after reset", W'(out_valid), W'(0));
  endtask

  task automatic t_three;   // R3 direct
    run(W'(3), ALL1C, ALL1W, 1'b0, 0);
    chk("R3 value",  r_val, W'(1));
    chk("R3 count",  W'(r_cnt), W'(2));
    chk("R3 peak",   r_peak, W'(5));
    chk("R3 cycles", W'(r_cyc), W'(2));
    chk("R5 drop flag only", W'(r_fl), W'(4'b0001));
  endtask

  task automatic t_halving; // R4
    run(W'(255), ALL1C, ALL1W, 1'b0, 0);
    chk("R4 value",  r_val, W'(205));
    chk("R4 count",  W'(r_cnt), W'(8));
    chk("R4 peak",   r_peak, W'(4373));
    chk("R4 cycles", W'(r_cyc), W'(10));
    chk("R5 drop after halving", W'(r_fl), W'(4'b0001));
  endtask

  task automatic t_even_start; // R2
    run(W'(254), ALL1C, ALL1W, 1'b0, 0);
    chk("R2 value",  r_val, W'(205));
    chk("R2 count",  W'(r_cnt), W'(8));
    chk("R2 peak",   r_peak, W'(4373));
  endtask

  task automatic t_record; // R6
    run(W'(27), CW'(2), ALL1W, 1'b0, 0);
    chk("R6 value",  r_val, W'(47));
    chk("R6 count",  W'(r_cnt), W'(3));
    chk("R6 flags",  W'(r_fl), W'(4'b0010));
    chk("R6 cycles", W'(r_cyc), W'(3));
  endtask

  task automatic t_max; // R7
    run(W'(27), ALL1C, W'(100), 1'b0, 0);
    chk("R7 value", r_val, W'(107));
    chk("R7 peak",  r_peak, W'(107));
    chk("R7 count", W'(r_cnt), W'(5));
    chk("R7 flags", W'(r_fl), W'(4'b0100));
  endtask

  task automatic t_both; // R11
    run(W'(255), CW'(2), W'(800), 1'b0, 0);
    chk("R11 value", r_val, W'(863));
    chk("R11 count", W'(r_cnt), W'(3));
    chk("R11 flags", W'(r_fl), W'(4'b0110));
  endtask

  task automatic t_overflow; // R8
    logic [W-1:0] third;
    third = {(W/4){4'h5}};
    run(third, ALL1C, ALL1W, 1'b0, 0);
    chk("R8 first-step value", r_val, third);
    chk("R8 first-step count", W'(r_cnt), W'(0));
    chk("R8 first-step peak",  r_peak, third);
    chk("R8 first-step flags", W'(r_fl), W'(4'b1000));
    chk("R8 first-step cycles", W'(r_cyc), W'(1));
    run(third - W'(2), ALL1C, ALL1W, 1'b0, 0);
    chk("R8 second-step value", r_val, (W'(1) << (W-1)) - W'(3));
    chk("R8 second-step count", W'(r_cnt), W'(1));
    chk("R8 second-step flags", W'(r_fl), W'(4'b1000));
    chk("R8 second-step cycles", W'(r_cyc), W'(2));
  endtask

  task automatic t_hold; // R9
    run(W'(27), CW'(2), ALL1W, 1'b0, 4);
    chk("R9 value after hold", r_val, W'(47));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1-run hung actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_start = '0; in_record = '0; in_max = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_three();
    t_halving();
    t_even_start();
    t_record();
    t_max();
    t_both();
    t_overflow();
    t_hold();
    vs_model("R1 busy poke ignored", W'(27), ALL1C, ALL1W, 1'b1);
    vs_model("R5 start 7",   W'(7),   ALL1C, ALL1W, 1'b0);
    vs_model("R5 start 97",  W'(97),  ALL1C, ALL1W, 1'b0);
    vs_model("R5 start 871", W'(871), ALL1C, ALL1W, 1'b0);
    vs_model("R3 start 1 record 5", W'(1), CW'(5), ALL1W, 1'b0);
    vs_model("R7 start 703 max 5000", W'(703), ALL1C, W'(5000), 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule